// File: doc/BRIEF.md
# YCbCr to RGB Pixel Converter

This block turns a stream of luma/chroma pixels into red, green and blue components, one pixel per clock when the source supplies one. Each pixel arrives with a valid strobe and two mode bits. One bit picks the colorimetry (601 or 709). The other picks the input range: full-swing samples, or studio-swing samples whose luma sits on a 16-code floor. The converted pixel leaves a fixed number of cycles later with its own valid strobe.

Inside, the block is a three-register pipeline. The first stage re-centres the two chroma samples around mid-scale and removes the luma floor when studio range is selected. The second stage forms the three weighted sums with signed fixed-point coefficients for the selected matrix. The third stage rounds each sum to an integer and clamps it into the output range. The two mode bits travel down the pipeline beside their pixel, so the source may switch matrix on any pixel.

Top module: `ycc2rgb_conv`

## Requirements
- R1: With sel_narrow=0, the mode is full range. With sel_709=0 the coefficients in units of 1/1024 are: luma 1024, R from Cr 1404, G from Cr 715, G from Cb 344, B from Cb 1774. With sel_709=1 they are 1024, 1577, 470, 187 and 1860. No luma offset is applied.
- R2: With sel_narrow=1, the mode is studio range and 16 is subtracted from luma. With sel_709=0 the coefficients in units of 1/1024 are: luma 1192, R from Cr 1634, G from Cr 833, G from Cb 400, B from Cb 2066. With sel_709=1 they are 1192, 1836, 547, 218 and 2166.
- R3: Each channel is computed from the integer sums S_R = kY·Yo + kRv·(Cr−128), S_G = kY·Yo − kGv·(Cr−128) − kGu·(Cb−128) and S_B = kY·Yo + kBu·(Cb−128), where Yo is the offset-corrected luma. Each sum is rounded as (S + 512) shifted arithmetically right by 10.
- R4: Every rounded result below 0 becomes 0, and every result above 255 becomes 255. In studio range with Cb=Cr=128, any luma of 16 or less yields 0 on all channels, and any luma of 235 or more yields 255 on all channels.
- R5: out_valid equals in_valid as sampled three rising edges earlier. A pixel that is presented without in_valid never produces an output pixel.
- R6: Each pixel is converted with the mode bits sampled together with that pixel, even when the mode bits change on every pixel.
- R7: While rst is high at a rising edge, out_valid is 0 after that edge. Pixels that were in flight when reset was taken never appear at the output.
- R8: In full range with Cb=Cr=128, all three outputs equal the input luma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| sel_709 | input | 1 | 1 selects 709 matrix, 0 selects 601 |
| sel_narrow | input | 1 | 1 selects studio range, 0 full range |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
A wrong coefficient or a wrong luma offset would show as an output value that differs from the reference, on the third cycle after the affected pixel enters. The mode bits are toggled on every pixel, so a pipeline stage that read a mode bit one cycle late would produce a miscompare on the first pixel after a mode change. A broken valid delay or an incomplete reset flush would show directly on out_valid, either as a pixel that appears where none was expected or as a missing pixel, in the cycle the mismatch arises.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

   typedef enum logic [1:0] {
      YCC_FULL_601   = 2'd0,
      YCC_FULL_709   = 2'd1,
      YCC_STUDIO_601 = 2'd2,
      YCC_STUDIO_709 = 2'd3
   } ycc_mode_e;

   localparam int N_MODES = 4;
   localparam int N_TERMS = 5;   // luma, R<-Cr, G<-Cr, G<-Cb, B<-Cb

   // coefficient magnitudes in thousandths
   function automatic int milli_coef(int mode, int term);
      int t [N_MODES][N_TERMS];
      t[0] = '{1000, 1371, 698, 336, 1732};
      t[1] = '{1000, 1540, 459, 183, 1816};
      t[2] = '{1164, 1596, 813, 391, 2018};
      t[3] = '{1164, 1793, 534, 213, 2115};
      return t[mode][term];
   endfunction

   // rounded conversion of thousandths into fixed point with frac bits
   function automatic int to_fixed(int milli, int frac);
      return (milli * (1 << frac) + 500) / 1000;
   endfunction

   function automatic int acc_width(int data_w, int frac);
      return data_w + frac + 6;
   endfunction

endpackage

// File: rtl/ycc_center.sv
module ycc_center
   import ycc2rgb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [DATA_W-1:0]        in_y,
   input  logic [DATA_W-1:0]        in_cb,
   input  logic [DATA_W-1:0]        in_cr,
   input  ycc_mode_e                in_mode,
   output logic                     c_valid,
   output logic signed [DATA_W:0]   c_luma,
   output logic signed [DATA_W:0]   c_cb,
   output logic signed [DATA_W:0]   c_cr,
   output ycc_mode_e                c_mode
);
   localparam int IN_W  = DATA_W + 1;
   localparam int MID   = 1 << (DATA_W - 1);
   localparam int Y_OFF = 16 << (DATA_W - 8);

   logic signed [IN_W-1:0] luma_ofs;

   assign luma_ofs = in_mode[1] ? IN_W'(Y_OFF) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         c_valid <= 1'b0;
      end else begin
         c_valid <= in_valid;
      end
      c_luma <= IN_W'({1'b0, in_y})  - luma_ofs;
      c_cb   <= IN_W'({1'b0, in_cb}) - IN_W'(MID);
      c_cr   <= IN_W'({1'b0, in_cr}) - IN_W'(MID);
      c_mode <= in_mode;
   end
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
   import ycc2rgb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC   = 10,
   localparam int IN_W  = DATA_W + 1,
   localparam int ACC_W = acc_width(DATA_W, FRAC)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    c_valid,
   input  logic signed [IN_W-1:0]  c_luma,
   input  logic signed [IN_W-1:0]  c_cb,
   input  logic signed [IN_W-1:0]  c_cr,
   input  ycc_mode_e               c_mode,
   output logic                    m_valid,
   output logic signed [ACC_W-1:0] m_acc [3]
);
   localparam int COEF_W = FRAC + 3;

   logic signed [COEF_W-1:0] k_tab [N_MODES][N_TERMS];

   for (genvar gm = 0; gm < N_MODES; gm++) begin : g_mode
      for (genvar gt = 0; gt < N_TERMS; gt++) begin : g_term
         assign k_tab[gm][gt] = COEF_W'(to_fixed(milli_coef(gm, gt), FRAC));
      end
   end

   logic signed [ACC_W-1:0] k_y, k_rv, k_gv, k_gu, k_bu;
   logic signed [ACC_W-1:0] x_l, x_u, x_v;
   logic signed [ACC_W-1:0] t_y, s_r, s_g, s_b;

   always_comb begin
      k_y  = ACC_W'(k_tab[int'(c_mode)][0]);
      k_rv = ACC_W'(k_tab[int'(c_mode)][1]);
      k_gv = ACC_W'(k_tab[int'(c_mode)][2]);
      k_gu = ACC_W'(k_tab[int'(c_mode)][3]);
      k_bu = ACC_W'(k_tab[int'(c_mode)][4]);
      x_l  = ACC_W'(c_luma);
      x_u  = ACC_W'(c_cb);
      x_v  = ACC_W'(c_cr);
      t_y  = k_y * x_l;
      s_r  = t_y + k_rv * x_v;
      s_g  = t_y - k_gv * x_v - k_gu * x_u;
      s_b  = t_y + k_bu * x_u;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_valid <= 1'b0;
      end else begin
         m_valid <= c_valid;
      end
      m_acc[0] <= s_r;
      m_acc[1] <= s_g;
      m_acc[2] <= s_b;
   end
endmodule

// File: rtl/ycc_saturate.sv
module ycc_saturate #(
   parameter int DATA_W = 8,
   parameter int FRAC   = 10,
   parameter int ACC_W  = 24
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [DATA_W-1:0]       pix
);
   localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1 << (FRAC - 1));
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << DATA_W) - 1);

   logic signed [ACC_W-1:0] rnd, whole;

   always_comb begin
      rnd   = acc + HALF;
      whole = rnd >>> FRAC;
      if (whole < 0)
         pix = '0;
      else if (whole > SAT_HI)
         pix = '1;
      else
         pix = whole[DATA_W-1:0];
   end
endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
   import ycc2rgb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC   = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_y,
   input  logic [DATA_W-1:0] in_cb,
   input  logic [DATA_W-1:0] in_cr,
   input  logic              sel_709,
   input  logic              sel_narrow,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_r,
   output logic [DATA_W-1:0] out_g,
   output logic [DATA_W-1:0] out_b
);
   localparam int IN_W  = DATA_W + 1;
   localparam int ACC_W = acc_width(DATA_W, FRAC);
   localparam int MID   = 1 << (DATA_W - 1);
   localparam int Y_LO  = 16 << (DATA_W - 8);
   localparam int Y_HI  = 235 << (DATA_W - 8);

   if (DATA_W < 8 || DATA_W > 12) begin : g_bad_data_w
      $error("ycc2rgb_conv: DATA_W must lie in 8..12");
   end
   if (FRAC < 6 || FRAC > 16) begin : g_bad_frac
      $error("ycc2rgb_conv: FRAC must lie in 6..16");
   end

   ycc_mode_e               in_mode;
   logic                    c_valid, m_valid;
   logic signed [IN_W-1:0]  c_luma, c_cb, c_cr;
   ycc_mode_e               c_mode;
   logic signed [ACC_W-1:0] m_acc [3];
   logic [DATA_W-1:0]       sat_pix [3];

   assign in_mode = ycc_mode_e'({sel_narrow, sel_709});

   ycc_center #(.DATA_W(DATA_W)) u_center (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_mode(in_mode),
      .c_valid(c_valid), .c_luma(c_luma), .c_cb(c_cb), .c_cr(c_cr),
      .c_mode(c_mode)
   );

   ycc_matrix #(.DATA_W(DATA_W), .FRAC(FRAC)) u_matrix (
      .clk(clk), .rst(rst), .c_valid(c_valid),
      .c_luma(c_luma), .c_cb(c_cb), .c_cr(c_cr), .c_mode(c_mode),
      .m_valid(m_valid), .m_acc(m_acc)
   );

   for (genvar gc = 0; gc < 3; gc++) begin : g_chan
      ycc_saturate #(.DATA_W(DATA_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_sat (
         .acc(m_acc[gc]), .pix(sat_pix[gc])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= m_valid;
      end
      out_r <= sat_pix[0];
      out_g <= sat_pix[1];
      out_b <= sat_pix[2];
   end

   // cycles since reset, saturating, so checks never reach before reset
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)            age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R7: reset empties the output
   p_reset_flush_r7: assert property (@(posedge clk) rst |=> !out_valid);

   // R5: valid follows input valid by three edges
   p_valid_delay_r5: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R8: neutral chroma in full range passes luma through
   p_grey_pass_r8: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(in_valid, 3) && !$past(sel_narrow, 3) &&
       $past(in_cb, 3) == DATA_W'(MID) && $past(in_cr, 3) == DATA_W'(MID))
      |-> (out_r == $past(in_y, 3) && out_g == $past(in_y, 3) &&
           out_b == $past(in_y, 3)));

   // R4: studio black floor clamps to zero
   p_black_clamp_r4: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(in_valid, 3) && $past(sel_narrow, 3) &&
       $past(in_cb, 3) == DATA_W'(MID) && $past(in_cr, 3) == DATA_W'(MID) &&
       $past(in_y, 3) <= DATA_W'(Y_LO))
      |-> (out_r == '0 && out_g == '0 && out_b == '0));

   // R4: studio white ceiling clamps to full scale
   p_white_clamp_r4: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(in_valid, 3) && $past(sel_narrow, 3) &&
       $past(in_cb, 3) == DATA_W'(MID) && $past(in_cr, 3) == DATA_W'(MID) &&
       $past(in_y, 3) >= DATA_W'(Y_HI))
      |-> (out_r == '1 && out_g == '1 && out_b == '1));
endmodule

// File: tb/tb_ycc2rgb_conv.sv
module tb_ycc2rgb_conv;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
   logic       sel_709 = 1'b0, sel_narrow = 1'b0;
   logic       out_valid;
   logic [7:0] out_r, out_g, out_b;

   always #5 clk = ~clk;

   ycc2rgb_conv dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
      .sel_709(sel_709), .sel_narrow(sel_narrow),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 0;
   string tag     = "R7";

   // coefficient sets from R1 and R2: luma, R<-Cr, G<-Cr, G<-Cb, B<-Cb
   int kt [4][5];
   initial begin
      kt[0] = '{1024, 1404, 715, 344, 1774};
      kt[1] = '{1024, 1577, 470, 187, 1860};
      kt[2] = '{1192, 1634, 833, 400, 2066};
      kt[3] = '{1192, 1836, 547, 218, 2166};
   end

   // reference pipeline, three deep
   bit pv [3];
   int pr [3], pg [3], pb [3];
   initial for (int i = 0; i < 3; i++) pv[i] = 0;

   function automatic int fin(int s);
      int t;
      t = (s + 512) >>> 10;
      if (t < 0)   t = 0;
      if (t > 255) t = 255;
      return t;
   endfunction

   task automatic step(bit r, bit v, int y, int cb, int cr, int m);
      int yo, u, w, base;
      @(negedge clk);
      vectors++;
      if (out_valid !== pv[2]) begin
         errors++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, pv[2]);
      end else if (pv[2] && (out_r !== 8'(pr[2]) || out_g !== 8'(pg[2]) || out_b !== 8'(pb[2]))) begin
         errors++;
         $display("FAIL %s rgb actual=%0d,%0d,%0d expected=%0d,%0d,%0d",
                  tag, out_r, out_g, out_b, pr[2], pg[2], pb[2]);
      end
      rst        = r;
      in_valid   = v;
      in_y       = 8'(y);
      in_cb      = 8'(cb);
      in_cr      = 8'(cr);
      sel_709    = m[0];
      sel_narrow = m[1];
      for (int i = 2; i > 0; i--) begin
         pv[i] = pv[i-1]; pr[i] = pr[i-1]; pg[i] = pg[i-1]; pb[i] = pb[i-1];
      end
      yo   = y - ((m >= 2) ? 16 : 0);
      u    = cb - 128;
      w    = cr - 128;
      base = kt[m][0] * yo;
      pv[0] = v;
      pr[0] = fin(base + kt[m][1] * w);
      pg[0] = fin(base - kt[m][2] * w - kt[m][3] * u);
      pb[0] = fin(base + kt[m][4] * u);
      if (r) for (int i = 0; i < 3; i++) pv[i] = 0;
   endtask

   function automatic int pick(int a, int b, int c, int d, int k);
      case (k) 0: return a; 1: return b; 2: return c; default: return d;
      endcase
   endfunction

   initial begin
      // R7: reset state and idle after reset
      tag = "R7";
      for (int i = 0; i < 3; i++) step(1, 1, 50, 60, 70, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
      // R8: neutral chroma luma sweep in both full-range matrices
      tag = "R8";
      for (int y = 0; y < 256; y++) step(0, 1, y, 128, 128, y & 1);
      // R1: full-range matrices, arbitrary pixels
      tag = "R1";
      for (int i = 0; i < 300; i++)
         step(0, 1, $urandom_range(255), $urandom_range(255), $urandom_range(255), $urandom_range(1));
      // R2: studio-range matrices
      tag = "R2";
      for (int i = 0; i < 300; i++)
         step(0, 1, $urandom_range(255), $urandom_range(255), $urandom_range(255), 2 + $urandom_range(1));
      // R4: corner samples that drive outputs past both rails
      tag = "R4";
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++)
                  step(0, 1, pick(0, 16, 235, 255, a), pick(0, 128, 255, 0, b),
                       pick(0, 128, 255, 0, c), m);
      for (int y = 0; y < 256; y += 5) step(0, 1, y, 128, 128, 2 + (y & 1));
      // R6: mode changes on every pixel
      tag = "R6";
      for (int i = 0; i < 300; i++)
         step(0, 1, $urandom_range(255), $urandom_range(255), $urandom_range(255), i % 4);
      // R5: bubbles in the valid stream
      tag = "R5";
      for (int i = 0; i < 300; i++)
         step(0, $urandom_range(1), $urandom_range(255), $urandom_range(255),
              $urandom_range(255), $urandom_range(3));
      // R3: rounding across mixed sums
      tag = "R3";
      for (int i = 0; i < 200; i++)
         step(0, 1, $urandom_range(255), 120 + $urandom_range(16), 120 + $urandom_range(16),
              $urandom_range(3));
      // R7: reset taken with pixels in flight
      tag = "R7";
      step(0, 1, 200, 10, 240, 0);
      step(0, 1, 30, 250, 5, 3);
      step(1, 1, 100, 100, 100, 1);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0);
      step(0, 1, 90, 128, 128, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule